// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Master

This block runs a small three-wire serial EEPROM (chip select, shift clock, serial data towards the device, serial data back from it). A client raises `req` for one cycle with an operation code, an address, write data and an address-width select. The block then builds the whole command frame itself and shifts it out. The frame holds the start bit, the opcode, the address and, where the operation needs it, the data or the data slot.

A read returns the sixteen bits captured during the last sixteen clocks of the frame. Write and erase need a programming cycle inside the device. For these two operations the block reselects the device after the frame and watches the returned data line until the device reports ready. It stops watching after a bounded number of poll intervals and flags a timeout.

The enable-programming and disable-programming frames are produced internally, so the client only names the operation. The shift-clock half period is a parameter, counted in system clock cycles. Completion is a one-cycle `done` pulse. It carries the read data and the timeout flag, and both values hold until the next completion.

Top module: `mw_eeprom_master`

## Requirements
- R1: Operation code 0 (read) sends a frame of 3 + W + 16 clocks, where W is the address width. The frame starts with bits 1,1,0, then the address MSB first. The device-bound data line is 0 during the last 16 clocks.
- R2: Operation code 1 (write) sends 1,0,1, then the address MSB first, then `wdata` MSB first, for 3 + W + 16 clocks.
- R3: Operation code 2 (erase) sends 1,1,1 followed by the address MSB first, for 3 + W clocks.
- R4: Operation code 3 (enable programming) sends 1,0,0 followed by W ones. Operation code 4 (disable programming) sends 1,0,0 followed by W zeros. Both frames are 3 + W clocks long.
- R5: For a read, the returned data line is sampled at the end of each high half of the shift clock. The samples from the last 16 clocks form `rdata` MSB first, and `rdata` is valid while `done` is high. Only reads change `rdata`.
- R6: Chip select is low while idle and drops at the end of every frame. The shift clock is never high while chip select is low.
- R7: After a write or an erase, the block raises chip select again with the clock low. It samples the returned line once per poll interval of HALF_DIV cycles and completes with `timeout`=0 on the first sample that reads 1.
- R8: If POLL_LIMIT consecutive poll samples read 0, the block completes with `timeout`=1. Chip select is then high for exactly POLL_LIMIT*HALF_DIV cycles of polling.
- R9: `addr_wide`=1 selects 8 address bits and `addr_wide`=0 selects 6. With 6 bits, `addr[7:6]` are not sent. The width is taken when the request is accepted.
- R10: `busy` rises in the cycle after an accepted request and falls in the same cycle that `done` pulses. A request is accepted in any cycle with `busy` low, including the cycle of `done`. A request while busy, or with an operation code of 5 to 7, has no effect.
- R11: Each half of the shift clock inside a frame lasts HALF_DIV system cycles. The device-bound data line is stable while the shift clock is high.
- R12: `done` is a single-cycle pulse. After reset, `busy`, `done`, `timeout`, `rdata`, chip select and the shift clock are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | One-cycle command request |
| op | input | 3 | Operation: 0 read, 1 write, 2 erase, 3 enable programming, 4 disable programming |
| addr_wide | input | 1 | 1 selects 8 address bits, 0 selects 6 |
| addr | input | 8 | Word address |
| wdata | input | 16 | Data for a write |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Data of the last read |
| timeout | output | 1 | Last program poll gave up |
| ee_cs | output | 1 | Device chip select |
| ee_sk | output | 1 | Device shift clock |
| ee_di | output | 1 | Serial data to the device |
| ee_do | input | 1 | Serial data and ready indication from the device |

## Verification
Completion and the next request can fall in the same cycle: `done` pulses while `busy` is already low, so a request presented in that cycle must start a new frame. The bench waits for `done` and drives the next request in that very cycle. It then checks that `busy` is high one cycle later and that the whole new frame arrives bit-exact. A second overlap is a request that arrives mid-frame. The bench injects one partway through an operation and judges it by checking that only the first frame reaches the device and that nothing follows it.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int MW_DATA_W  = 16;
  localparam int MW_FRAME_W = 3 + 8 + MW_DATA_W;
  localparam int MW_LEN_W   = $clog2(MW_FRAME_W + 1);

  localparam logic [2:0] MW_OP_READ  = 3'd0;
  localparam logic [2:0] MW_OP_WRITE = 3'd1;
  localparam logic [2:0] MW_OP_ERASE = 3'd2;
  localparam logic [2:0] MW_OP_WEN   = 3'd3;
  localparam logic [2:0] MW_OP_WDIS  = 3'd4;

  function automatic logic mw_op_valid(input logic [2:0] op);
    return op <= MW_OP_WDIS;
  endfunction

  function automatic logic mw_needs_poll(input logic [2:0] op);
    return (op == MW_OP_WRITE) || (op == MW_OP_ERASE);
  endfunction

  function automatic logic [MW_LEN_W-1:0] mw_len(input logic [2:0] op, input logic wide);
    logic [MW_LEN_W-1:0] n;
    n = wide ? MW_LEN_W'(11) : MW_LEN_W'(9);
    if (op == MW_OP_READ || op == MW_OP_WRITE) n = n + MW_LEN_W'(MW_DATA_W);
    return n;
  endfunction

  // Frame left aligned: first bit to send sits at the MSB.
  function automatic logic [MW_FRAME_W-1:0] mw_frame(input logic [2:0] op, input logic wide,
                                                      input logic [7:0] addr,
                                                      input logic [MW_DATA_W-1:0] data);
    logic [2:0]           head;
    logic [7:0]           a;
    logic [MW_DATA_W-1:0] d;
    head = 3'b110;
    a    = addr;
    d    = '0;
    case (op)
      MW_OP_WRITE: begin head = 3'b101; d = data; end
      MW_OP_ERASE: head = 3'b111;
      MW_OP_WEN:   begin head = 3'b100; a = 8'hFF; end
      MW_OP_WDIS:  begin head = 3'b100; a = 8'h00; end
      default:     head = 3'b110;
    endcase
    if (wide) return {head, a, d};
    return {head, a[5:0], d, 2'b00};
  endfunction
endpackage

// File: rtl/mw_tick_gen.sv
module mw_tick_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV + 1);
  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(HALF_DIV - 1)) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (restart || tick)  cnt <= '0;
    else                       cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/mw_frame_shifter.sv
module mw_frame_shifter
  import mw_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [MW_FRAME_W-1:0] frame_in,
  input  logic [MW_LEN_W-1:0]   len_in,
  input  logic                  step,
  input  logic                  sample_in,
  output logic                  tx_bit,
  output logic                  last,
  output logic [MW_DATA_W-1:0]  rx_word
);
  logic [MW_FRAME_W-1:0] sh;
  logic [MW_LEN_W-1:0]   left;

  assign tx_bit = sh[MW_FRAME_W-1];
  assign last   = (left == MW_LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      left    <= '0;
      rx_word <= '0;
    end else if (load) begin
      sh      <= frame_in;
      left    <= len_in;
      rx_word <= '0;
    end else if (step) begin
      sh      <= {sh[MW_FRAME_W-2:0], 1'b0};
      left    <= left - MW_LEN_W'(1);
      rx_word <= {rx_word[MW_DATA_W-2:0], sample_in};
    end
  end
endmodule

// File: rtl/mw_ready_poll.sv
module mw_ready_poll #(
  parameter int POLL_LIMIT = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sample_en,
  input  logic ready_in,
  output logic ready,
  output logic expired
);
  localparam int PCW = $clog2(POLL_LIMIT + 1);
  logic [PCW-1:0] cnt;

  assign ready   = sample_en && ready_in;
  assign expired = sample_en && !ready_in && (cnt == PCW'(POLL_LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (start)     cnt <= '0;
    else if (sample_en) cnt <= cnt + PCW'(1);
  end
endmodule

// File: rtl/mw_eeprom_master.sv
module mw_eeprom_master
  import mw_pkg::*;
#(
  parameter int HALF_DIV   = 2,
  parameter int POLL_LIMIT = 10000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [2:0]  op,
  input  logic        addr_wide,
  input  logic [7:0]  addr,
  input  logic [15:0] wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata,
  output logic        timeout,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  input  logic        ee_do
);
  typedef enum logic [2:0] {ST_IDLE, ST_LOW, ST_HIGH, ST_GAP, ST_POLL} st_e;

  st_e                  st;
  logic [2:0]           op_q;
  logic                 tick, accept, bit_end, poll_tick, last_bit, tx_bit;
  logic                 poll_ready, poll_expired;
  logic [MW_DATA_W-1:0] rx_word;

  assign accept    = (st == ST_IDLE) && req && mw_op_valid(op);
  assign bit_end   = (st == ST_HIGH) && tick;
  assign poll_tick = (st == ST_POLL) && tick;

  mw_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(accept), .tick(tick)
  );

  mw_frame_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .frame_in(mw_frame(op, addr_wide, addr, wdata)),
    .len_in(mw_len(op, addr_wide)),
    .step(bit_end), .sample_in(ee_do),
    .tx_bit(tx_bit), .last(last_bit), .rx_word(rx_word)
  );

  mw_ready_poll #(.POLL_LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst_n(rst_n), .start(accept), .sample_en(poll_tick),
    .ready_in(ee_do), .ready(poll_ready), .expired(poll_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      op_q    <= '0;
      done    <= 1'b0;
      rdata   <= '0;
      timeout <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          st   <= ST_LOW;
          op_q <= op;
        end
        ST_LOW:  if (tick) st <= ST_HIGH;
        ST_HIGH: if (tick) st <= last_bit ? ST_GAP : ST_LOW;
        ST_GAP: if (tick) begin
          if (mw_needs_poll(op_q)) st <= ST_POLL;
          else begin
            st      <= ST_IDLE;
            done    <= 1'b1;
            timeout <= 1'b0;
            if (op_q == MW_OP_READ) rdata <= rx_word;
          end
        end
        ST_POLL: if (poll_ready || poll_expired) begin
          st      <= ST_IDLE;
          done    <= 1'b1;
          timeout <= poll_expired;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy  = (st != ST_IDLE);
  assign ee_cs = (st == ST_LOW) || (st == ST_HIGH) || (st == ST_POLL);
  assign ee_sk = (st == ST_HIGH);
  assign ee_di = ((st == ST_LOW) || (st == ST_HIGH)) && tx_bit;
endmodule

// File: rtl/mw_eeprom_master_chk.sv
module mw_eeprom_master_chk #(
  parameter int HALF_DIV = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic [15:0] rdata,
  input logic        ee_cs,
  input logic        ee_sk,
  input logic        ee_di
);
  logic       sk_q;
  logic [7:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_q    <= 1'b0;
      run_len <= '0;
    end else begin
      sk_q <= ee_sk;
      if (ee_sk != sk_q)        run_len <= 8'd1;
      else if (run_len != 8'hFF) run_len <= run_len + 8'd1;
    end
  end

  AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_cs |-> !ee_sk); // R6
  AST_HIGH_HALF_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ee_sk && sk_q) |-> run_len == 8'(HALF_DIV)); // R11
  AST_DI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di)); // R11
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12
  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rdata)); // R5
endmodule

bind mw_eeprom_master mw_eeprom_master_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rdata(rdata),
  .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di)
);

// File: tb/test_mw_eeprom_master.sv
module test_mw_eeprom_master;
  localparam int HD = 2;
  localparam int PL = 10000;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, addr_wide = 1'b0;
  logic [2:0] op = '0;
  logic [7:0] addr = '0;
  logic [15:0] wdata = '0;
  logic busy, done, timeout, ee_cs, ee_sk, ee_di, ee_do;
  logic [15:0] rdata;

  int total = 0, bad = 0, cycles = 0;

  mw_eeprom_master #(.HALF_DIV(HD), .POLL_LIMIT(PL)) i_mw_eeprom_master (
    .clk(clk), .rst_n(rst_n), .req(req), .op(op), .addr_wide(addr_wide),
    .addr(addr), .wdata(wdata), .busy(busy), .done(done), .rdata(rdata),
    .timeout(timeout), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  // ---------------- device model ----------------
  logic [26:0] cap;
  int ncap, pre, poll_cycles, ready_after, run;
  logic dev_rd, do_read, do_ready, frame_over, prev_sk, sk_bad;
  logic [15:0] dev_data;
  assign ee_do = do_read | do_ready;

  initial begin
    cap = '0; ncap = 0; pre = 9; poll_cycles = 0; ready_after = 0; run = 0;
    dev_rd = 0; do_read = 0; do_ready = 0; frame_over = 0; prev_sk = 0; sk_bad = 0;
    dev_data = '0;
  end

  always @(posedge ee_sk) if (ee_cs) begin
    if (ncap < 27) cap[26-ncap] = ee_di;
    ncap = ncap + 1;
    if (dev_rd && ncap > pre && ncap <= pre + 16) do_read <= dev_data[15-(ncap-pre-1)];
    else do_read <= 1'b0;
  end

  always @(negedge ee_cs) frame_over = 1'b1;

  always @(negedge clk) begin
    if (frame_over && ee_cs) begin
      poll_cycles = poll_cycles + 1;
      if (ready_after >= 0 && poll_cycles >= ready_after) do_ready = 1'b1;
    end
    if (ee_cs && !frame_over) begin
      if (ee_sk == prev_sk) run = run + 1;
      else begin
        if (run != HD) sk_bad = 1'b1;
        run = 1;
      end
      prev_sk = ee_sk;
    end
  end

  // ---------------- reference ----------------
  function automatic int ref_len(input logic [2:0] o, input logic w);
    return 3 + (w ? 8 : 6) + ((o <= 3'd1) ? 16 : 0);
  endfunction

  function automatic logic [26:0] ref_frame(input logic [2:0] o, input logic w,
                                            input logic [7:0] a, input logic [15:0] d);
    logic [26:0] f;
    logic [2:0] h;
    int n, aw;
    f = '0; n = 0; aw = w ? 8 : 6;
    h = (o == 3'd0) ? 3'b110 : (o == 3'd1) ? 3'b101 : (o == 3'd2) ? 3'b111 : 3'b100;
    for (int i = 2; i >= 0; i--) begin f[26-n] = h[i]; n++; end
    for (int i = aw - 1; i >= 0; i--) begin
      f[26-n] = (o == 3'd3) ? 1'b1 : (o == 3'd4) ? 1'b0 : a[i];
      n++;
    end
    if (o <= 3'd1)
      for (int i = 15; i >= 0; i--) begin f[26-n] = (o == 3'd1) ? d[i] : 1'b0; n++; end
    return f;
  endfunction

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- stimulus ----------------
  logic [2:0] e_op;
  logic e_w;
  logic [7:0] e_a;
  logic [15:0] e_d;
  int e_ra;

  // caller is at a negedge; leaves at the next negedge with req low
  task automatic arm(input logic [2:0] o, input logic w, input logic [7:0] a,
                     input logic [15:0] d, input int ra);
    e_op = o; e_w = w; e_a = a; e_d = d; e_ra = ra;
    cap = '0; ncap = 0; frame_over = 0; poll_cycles = 0; do_ready = 0;
    run = 0; prev_sk = 0; sk_bad = 0;
    ready_after = ra; dev_rd = (o == 3'd0); pre = w ? 11 : 9;
    dev_data = 16'($urandom);
    op = o; addr_wide = w; addr = a; wdata = d; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_done();
    int lim;
    lim = 0;
    while (!done && lim < 60000) begin @(negedge clk); lim++; end
    if (!done) chk(1'b0, "watchdog", 0, 1);
  endtask

  task automatic judge();
    chk(ncap == ref_len(e_op, e_w), {tag_of(e_op), " length"}, ncap, ref_len(e_op, e_w));
    chk(cap == ref_frame(e_op, e_w, e_a, e_d), {tag_of(e_op), " R9 frame"},
        cap, ref_frame(e_op, e_w, e_a, e_d));
    if (e_op == 3'd0) chk(rdata == dev_data, "R5 read data", rdata, dev_data);
    if (e_op == 3'd1 || e_op == 3'd2) begin
      if (e_ra < 0) begin
        chk(timeout == 1'b1, "R8 timeout flag", timeout, 1);
        chk(poll_cycles == PL * HD, "R8 poll span", poll_cycles, PL * HD);
      end else begin
        chk(timeout == 1'b0 && do_ready, "R7 ready seen", {timeout, do_ready}, 2'b01);
      end
    end else begin
      chk(timeout == 1'b0 && poll_cycles == 0, "R6 no poll", poll_cycles, 0);
    end
    chk(ee_cs == 1'b0, "R6 cs low at end", ee_cs, 0);
    chk(sk_bad == 1'b0, "R11 half period", sk_bad, 0);
  endtask

  task automatic run_op(input logic [2:0] o, input logic w, input logic [7:0] a,
                        input logic [15:0] d, input int ra);
    arm(o, w, a, d, ra);
    chk(busy == 1'b1, "R10 busy after accept", busy, 1);
    wait_done();
    judge();
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R12 done pulse", {done, busy}, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && timeout == 0 && rdata == 0 && ee_cs == 0 && ee_sk == 0,
        "R12 reset state", {busy, done, timeout, ee_cs, ee_sk}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    run_op(3'd3, 1'b0, 8'h00, 16'h0, 0);       // enable, 6-bit
    run_op(3'd3, 1'b1, 8'h00, 16'h0, 0);       // enable, 8-bit
    run_op(3'd4, 1'b0, 8'hFF, 16'hFFFF, 0);    // disable, 6-bit
    run_op(3'd4, 1'b1, 8'hFF, 16'hFFFF, 0);    // disable, 8-bit
    run_op(3'd0, 1'b0, 8'hC5, 16'h0, 0);       // read, upper addr bits dropped (R9)
    run_op(3'd0, 1'b1, 8'hA7, 16'h0, 0);
    run_op(3'd1, 1'b1, 8'h3C, 16'h8001, 0);    // ready immediately
    run_op(3'd2, 1'b0, 8'hFF, 16'h0, 37);
    run_op(3'd1, 1'b0, 8'h15, 16'hBEEF, -1);   // never ready: timeout

    // invalid op code ignored (R10)
    op = 3'd6; req = 1'b1;
    @(negedge clk); req = 1'b0;
    repeat (4) @(negedge clk);
    chk(busy == 0 && ee_cs == 0 && done == 0, "R10 invalid op ignored", {busy, ee_cs}, 0);

    // request while busy ignored (R10)
    arm(3'd3, 1'b1, 8'h00, 16'h0, 0);
    repeat (5) @(negedge clk);
    op = 3'd2; addr = 8'h11; req = 1'b1;
    @(negedge clk); req = 1'b0;
    wait_done();
    judge();
    repeat (6) @(negedge clk);
    chk(busy == 0 && ncap == ref_len(3'd3, 1'b1), "R10 busy request ignored", ncap,
        ref_len(3'd3, 1'b1));

    // request in the done cycle (R10)
    arm(3'd0, 1'b1, 8'h5A, 16'h0, 0);
    wait_done();
    judge();
    arm(3'd1, 1'b0, 8'h2B, 16'h1234, 5);
    chk(busy == 1'b1, "R10 accept on done cycle", busy, 1);
    wait_done();
    judge();
    @(negedge clk);

    // random mix
    for (int k = 0; k < 24; k++) begin
      run_op(3'($urandom_range(0, 4)), 1'($urandom), 8'($urandom), 16'($urandom),
             $urandom_range(0, 40));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=<200000", cycles);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule